// File: doc/BRIEF.md
# Feed-Sequenced Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Software loads a reload constant and sets the enable bit in the mode register. From then on it must keep the system alive by writing a two-word unlock pair to the feed register. The pair is 0xAA followed by 0x55. If the down-counter runs out, the block sets a timeout flag and a sticky wake flag. The wake flag drives the interrupt line. When reset-on-timeout is selected, the block also pulses a system reset request.

Any out-of-sequence value written to the feed register while the watchdog is enabled fires the timeout action at once. Software can use this to force a reset. The count advances once for every eight input clocks: a divide-by-two prescaler feeds a divide-by-four decrement stage. With constant C, the timeout therefore falls 8·(C+1) clocks after a valid feed. Software can set the enable bit but cannot clear it; only a block reset disables the watchdog.

Top module: `guard_timer`

## Requirements
- R1: After reset the mode word reads 0, the constant and counter words both read 0xFF, and `irq_o` and `sys_rst_req_o` are low.
- R2: Only exact byte addresses decode: 0x0 mode, 0x4 constant, 0x8 feed, 0xC counter. The mode word reads bits [3:0] as {wake, timeout, reset-select, enable} with zeros above. The feed word reads 0. Writes to the counter word are ignored. The other addresses read 0.
- R3: A constant write below 0xFF stores 0xFF. Larger values are stored as written.
- R4: Writing 1 to mode bit 0 enables the watchdog. Writing 0 to that bit never disables it.
- R5: A feed write of 0xAA, with 0x55 as the very next feed write, is a valid feed and reloads the counter from the constant. The counter holds until the block is enabled and has seen a valid feed while enabled.
- R6: While running, the counter decrements once every 8 clocks. A timeout occurs 8·(C+1) clocks after the valid feed that loaded constant C.
- R7: A timeout sets mode bit 2 (timeout) and mode bit 3 (wake). `irq_o` equals the wake bit.
- R8: Writing 0 to mode bit 2 clears the timeout flag. No write clears the wake flag.
- R9: On each timeout, `sys_rst_req_o` is high for one clock, and only if mode bit 1 was set.
- R10: While enabled, a feed write that breaks the 0xAA/0x55 pair triggers a timeout at once. While disabled, such a write has no effect.
- R11: On expiry the counter reloads from the constant and keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset, the only way to disable the watchdog |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt, level of the wake flag |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The embedded properties check the following on every cycle:
- the enable and wake flags never fall;
- the constant never drops below its floor;
- a reset request always has reset-select behind it and the wake flag already set;
- the timeout flag is set whenever the wake flag rises;
- the counter stays put while it is neither running nor being reloaded.

Only the bench scenarios can show whether the following are right:
- the exact 8·(C+1) expiry distance;
- the meaning of each feed pattern, and that a broken pair is ignored while disabled;
- the reload after expiry;
- the register read values.

The behavioural model compares these on every clock.

// File: rtl/gt_pkg.sv
package gt_pkg;
   localparam int MB_EN   = 0;
   localparam int MB_RSEL = 1;
   localparam int MB_TOF  = 2;
   localparam int MB_WAKE = 3;

   localparam int OFS_MODE  = 'h0;
   localparam int OFS_CONST = 'h4;
   localparam int OFS_FEED  = 'h8;
   localparam int OFS_COUNT = 'hC;

   localparam int FEED_FIRST  = 'hAA;
   localparam int FEED_SECOND = 'h55;

   typedef enum logic {
      FS_IDLE      = 1'b0,
      FS_GOT_FIRST = 1'b1
   } feed_state_t;
endpackage

// File: rtl/gt_feed.sv
module gt_feed
   import gt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_feed_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              en_i,
   output logic              good_o,
   output logic              bad_o
);
   feed_state_t st_q;
   logic is_first, is_second, opens;

   assign is_first  = (data_i == DATA_W'(FEED_FIRST));
   assign is_second = (data_i == DATA_W'(FEED_SECOND));
   assign opens     = (st_q == FS_IDLE) && is_first;

   assign good_o = wr_feed_i && (st_q == FS_GOT_FIRST) && is_second;
   assign bad_o  = wr_feed_i && en_i && !opens && !good_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= FS_IDLE;
      end else if (wr_feed_i) begin
         st_q <= opens ? FS_GOT_FIRST : FS_IDLE;
      end
   end
endmodule

// File: rtl/gt_count.sv
module gt_count #(
   parameter int CNT_W     = 32,
   parameter int DIV_TOTAL = 8,
   parameter int RST_VAL   = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   generate
      if (DIV_TOTAL < 1) begin : g_bad
         $error("DIV_TOTAL must be at least 1");
      end
      if (DIV_TOTAL == 1) begin : g_nodiv
         assign at_last = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(DIV_TOTAL);
         localparam logic [DW-1:0] LAST = DW'(DIV_TOTAL - 1);
         logic [DW-1:0] div_q;
         assign at_last = (div_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (load_i)           div_q <= '0;
            else if (run_i && at_last) div_q <= '0;
            else if (run_i)            div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   assign expire_o = run_i && !load_i && at_last && (cnt_q == '0);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= CNT_W'(RST_VAL);
      else if (load_i)           cnt_q <= load_val_i;
      else if (expire_o)         cnt_q <= load_val_i;
      else if (run_i && at_last) cnt_q <= cnt_q - 1'b1;
   end

   assert_hold_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
   import gt_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int CONST_MIN = 255,
   parameter int PRE_DIV   = 2,
   parameter int DEC_TICKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              sys_rst_req_o
);
   localparam int DIV_TOTAL = PRE_DIV * DEC_TICKS;
   localparam logic [DATA_W-1:0] FLOOR = DATA_W'(CONST_MIN);

   generate
      if (DATA_W < 9)  begin : g_chk_dw $error("DATA_W too small"); end
      if (ADDR_W < 4)  begin : g_chk_aw $error("ADDR_W too small"); end
      if (PRE_DIV < 1 || DEC_TICKS < 1) begin : g_chk_div $error("divider must be positive"); end
   endgenerate

   logic              en_q, rsel_q, tof_q, wake_q, armed_q, req_q;
   logic [DATA_W-1:0] tc_q, cnt;
   logic              wr, wr_mode, wr_const, wr_feed;
   logic              feed_good, feed_bad, expire, evt, run;

   assign wr       = bus_valid && bus_write;
   assign wr_mode  = wr && (bus_addr == ADDR_W'(OFS_MODE));
   assign wr_const = wr && (bus_addr == ADDR_W'(OFS_CONST));
   assign wr_feed  = wr && (bus_addr == ADDR_W'(OFS_FEED));

   gt_feed #(.DATA_W(DATA_W)) i_feed (
      .clk(clk), .rst_n(rst_n), .wr_feed_i(wr_feed), .data_i(bus_wdata),
      .en_i(en_q), .good_o(feed_good), .bad_o(feed_bad));

   assign run = en_q && armed_q;

   gt_count #(.CNT_W(DATA_W), .DIV_TOTAL(DIV_TOTAL), .RST_VAL(CONST_MIN)) i_count (
      .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(feed_good),
      .load_val_i(tc_q), .cnt_o(cnt), .expire_o(expire));

   assign evt = expire || feed_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rsel_q  <= 1'b0;
         tof_q   <= 1'b0;
         wake_q  <= 1'b0;
         armed_q <= 1'b0;
         req_q   <= 1'b0;
         tc_q    <= FLOOR;
      end else begin
         if (wr_mode && bus_wdata[MB_EN]) en_q <= 1'b1;
         if (wr_mode) rsel_q <= bus_wdata[MB_RSEL];
         if (evt) tof_q <= 1'b1;
         else if (wr_mode && !bus_wdata[MB_TOF]) tof_q <= 1'b0;
         if (evt) wake_q <= 1'b1;
         if (feed_good && en_q) armed_q <= 1'b1;
         req_q <= evt && rsel_q;
         if (wr_const) tc_q <= (bus_wdata < FLOOR) ? FLOOR : bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_MODE): begin
            bus_rdata[MB_EN]   = en_q;
            bus_rdata[MB_RSEL] = rsel_q;
            bus_rdata[MB_TOF]  = tof_q;
            bus_rdata[MB_WAKE] = wake_q;
         end
         ADDR_W'(OFS_CONST): bus_rdata = tc_q;
         ADDR_W'(OFS_COUNT): bus_rdata = cnt;
         default:            bus_rdata = '0;
      endcase
   end

   assign irq_o         = wake_q;
   assign sys_rst_req_o = req_q;

   assert_en_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);
   assert_wake_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |=> wake_q);
   assert_req_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req_o |-> ($past(rsel_q) && wake_q));
   assert_tc_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q >= FLOOR);
   assert_tof_on_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_q) |-> tof_q);
endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, sys_rst_req_o;

   int n_tests = 0, n_fail = 0, cycles = 0, pulses = 0;

   guard_timer i_guard_timer (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_en, m_rs, m_tof, m_wake, m_armed, m_fst, m_req, m_div;
   longint m_tc, m_cnt;
   int o_en, o_rs, good, bad, expd, ev, nf;
   longint o_tc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_rs = 0; m_tof = 0; m_wake = 0; m_armed = 0; m_fst = 0;
         m_req = 0; m_div = 0; m_tc = 255; m_cnt = 255;
      end else begin
         o_en = m_en; o_rs = m_rs; o_tc = m_tc;
         good = 0; bad = 0; expd = 0; nf = m_fst;
         if (bus_valid && bus_write && bus_addr == 4'h8) begin
            good = (m_fst == 1 && bus_wdata == 32'h55);
            bad  = (o_en == 1) && !(m_fst == 0 && bus_wdata == 32'hAA) && !good;
            nf   = (!good && !bad && m_fst == 0 && bus_wdata == 32'hAA) ? 1 : 0;
         end
         if (good) begin
            m_cnt = o_tc; m_div = 0;
         end else if (o_en && m_armed) begin
            if (m_div == 7) begin
               m_div = 0;
               if (m_cnt == 0) begin expd = 1; m_cnt = o_tc; end
               else m_cnt = m_cnt - 1;
            end else m_div = m_div + 1;
         end
         m_fst = nf;
         ev = expd || bad;
         m_req = (ev && o_rs) ? 1 : 0;
         if (good && o_en) m_armed = 1;
         if (bus_valid && bus_write && bus_addr == 4'h0) begin
            if (bus_wdata[0]) m_en = 1;
            m_rs = bus_wdata[1];
            if (!ev && !bus_wdata[2]) m_tof = 0;
         end
         if (ev) begin m_tof = 1; m_wake = 1; end
         if (bus_valid && bus_write && bus_addr == 4'h4)
            m_tc = (bus_wdata < 255) ? 255 : bus_wdata;
      end
   end

   function automatic longint model_read(logic [3:0] a);
      case (a)
         4'h0: return longint'(m_en + 2*m_rs + 4*m_tof + 8*m_wake);
         4'h4: return m_tc;
         4'hC: return m_cnt;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(irq_o == m_wake[0], "R7 irq", irq_o, m_wake);
         chk(sys_rst_req_o == m_req[0], "R9 req", sys_rst_req_o, m_req);
         chk(bus_rdata == model_read(bus_addr), "R2 rdata", bus_rdata, model_read(bus_addr));
         if (sys_rst_req_o) pulses++;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #2;
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic rd(input logic [3:0] a, input longint exp, input string req);
      bus_addr = a; #1;
      chk(bus_rdata == exp[31:0], req, bus_rdata, exp);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         chk(0, "watchdog", cycles, 150000);
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(posedge clk); #2;
      // R1 reset state
      rd(4'h0, 0, "R1 mode");
      rd(4'h4, 255, "R1 const");
      rd(4'hC, 255, "R1 count");
      chk(!irq_o && !sys_rst_req_o, "R1 outputs", {irq_o, sys_rst_req_o}, 0);
      rd(4'h8, 0, "R2 feed reads zero");
      rd(4'h2, 0, "R2 unaligned reads zero");
      // R3 clamp
      wr(4'h4, 32'h10);  rd(4'h4, 255, "R3 clamp");
      wr(4'h4, 32'h300); rd(4'h4, 32'h300, "R3 large");
      wr(4'h4, 32'h100);
      // R2 counter read-only
      wr(4'hC, 32'h1234); rd(4'hC, 255, "R2 count read-only");
      // R10 bad feed while disabled
      wr(4'h8, 32'h12); repeat (2) @(posedge clk); #2;
      rd(4'h0, 0, "R10 disabled bad feed ignored");
      // R5 enabled but not armed
      wr(4'h0, 32'h1); repeat (20) @(posedge clk); #2;
      rd(4'hC, 255, "R5 hold until fed");
      // R4 sticky enable
      wr(4'h0, 32'h0); rd(4'h0, 1, "R4 enable sticky");
      // R5 valid feed
      wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
      rd(4'hC, 32'h100, "R5 reload");
      repeat (24) @(posedge clk); #2;
      rd(4'hC, 32'h100 - 3, "R6 decrement rate");
      // R6 expiry distance with floor constant
      wr(4'h4, 32'h0);
      wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
      begin
         int n = 0;
         bus_addr = 4'hC;
         while (!irq_o && n < 5000) begin @(posedge clk); #2; n++; end
         chk(n == 2048, "R6 expiry distance", n, 2048);
         rd(4'hC, 255, "R11 reload after expiry");
      end
      rd(4'h0, 32'hD, "R7 flags set");
      chk(pulses == 0, "R9 no request without select", pulses, 0);
      repeat (16) @(posedge clk); #2;
      rd(4'hC, 253, "R11 keeps running");
      // R8 clear timeout flag, wake stays
      wr(4'h0, 32'h1); rd(4'h0, 32'h9, "R8 tof cleared wake kept");
      wr(4'h0, 32'h8); rd(4'h0, 32'h9, "R8 wake not writable");
      chk(irq_o == 1'b1, "R7 irq level", irq_o, 1);
      // R9 / R10 with reset select
      wr(4'h0, 32'h3);
      wr(4'h8, 32'h77);
      rd(4'h0, 32'hF, "R10 immediate timeout");
      repeat (2) @(posedge clk); #2;
      chk(pulses == 1, "R9 single pulse", pulses, 1);
      wr(4'h0, 32'h3);
      wr(4'h8, 32'hAA); wr(4'h8, 32'h12);
      repeat (2) @(posedge clk); #2;
      chk(pulses == 2, "R10 broken pair", pulses, 2);
      wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
      repeat (2) @(posedge clk); #2;
      chk(pulses == 3, "R10 repeated first word", pulses, 3);
      wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
      repeat (2) @(posedge clk); #2;
      chk(pulses == 3, "R5 valid pair no timeout", pulses, 3);
      rd(4'hC, 255, "R5 reload again");
      summary();
   end
endmodule